// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block sits behind a bank of address and data comparators in an on-chip debug unit. It walks through three programmable intermediate states and ends in a Final state. Each comparator match can move it to a new state. For every pair of intermediate state and comparator, a code chosen by software sets where that match leads. A match can be resolved in one of two ways. A force match takes effect at the first instruction-boundary strobe after it. A tagged match waits until the tagged opcode reaches execution.

Four shortcut sources skip the programmed path and jump straight to Final:
- two external tag lines,
- a coprocessor software breakpoint request,
- a software trigger pulse.

On entering Final, the block raises a single-cycle breakpoint request of the selected kind. It can also start trace capture, which stays on while the sequencer holds Final. Trace is masked while the system is in secure mode. Dropping the arm input sends the block back to idle.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset `state_o` is 4 (idle) and all outputs are low. While idle with `arm_i` high, the next clock edge moves the state to 0 (State1).
- R2: The state encoding is 0/1/2/3 = State1/State2/State3/Final. The transition code for comparator c in intermediate state s is `nxt_cfg_i[(s*NUM_CMP+c)*2 +: 2]`, and it uses the same 0..3 encoding. A force match (`cmp_tagged_i[c]`=0) is latched and applied at the first `boundary_i` strobe in a later cycle. A boundary strobe in the same cycle as the match does not count.
- R3: A tagged match (`cmp_tagged_i[c]`=1) is applied only at a later `tag_hit_i` strobe. Boundary strobes do not resolve it.
- R4: When several comparators match in the same cycle, the lowest-indexed one is taken.
- R5: While a trigger is pending, further matches are dropped. The pending target stays unchanged until it resolves.
- R6: Any of `tag_hi_i`, `tag_lo_i`, `cop_brk_i` or `sw_trig_i`, while armed in an intermediate state, moves the state to Final at the next edge. This discards any pending trigger.
- R7: On entering Final, exactly one cycle of breakpoint request is raised, chosen by `brk_sel_i`: 0 none, 1 `brk_dbg_o` (enter debug mode), 2 `brk_swi_o` (software interrupt), 3 `brk_cop_o` (coprocessor).
- R8: `trace_en_o` rises on the edge that enters Final if `trace_req_i` was high in that cycle. It stays high while Final is held.
- R9: `trace_en_o` is low in any cycle where `secure_i` is high.
- R10: When `arm_i` is low, the next state is idle, trace is dropped and the pending trigger is cleared. All trigger inputs are ignored while idle.
- R11: Final holds while armed. Matches and shortcut sources in Final change neither the state nor the breakpoint outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm control; low forces idle |
| cmp_match_i | input | NUM_CMP | Comparator match pulses |
| cmp_tagged_i | input | NUM_CMP | Per comparator: 1 tagged, 0 force |
| nxt_cfg_i | input | 3*NUM_CMP*2 | Next-state codes per state and comparator |
| tag_hi_i | input | 1 | External tag line, high half |
| tag_lo_i | input | 1 | External tag line, low half |
| cop_brk_i | input | 1 | Coprocessor software breakpoint request |
| sw_trig_i | input | 1 | Software trigger pulse |
| boundary_i | input | 1 | Instruction-boundary strobe |
| tag_hit_i | input | 1 | Tagged opcode reached execution |
| secure_i | input | 1 | System secured; masks trace |
| trace_req_i | input | 1 | Start trace on Final entry |
| brk_sel_i | input | 2 | Breakpoint kind select |
| state_o | output | 3 | Current state (0..3, 4 idle) |
| trace_en_o | output | 1 | Trace capture enable |
| brk_dbg_o | output | 1 | Breakpoint into debug mode |
| brk_swi_o | output | 1 | Breakpoint via software interrupt |
| brk_cop_o | output | 1 | Coprocessor breakpoint |

## Verification
Some properties are checked by assertions on every cycle:
- an armed shortcut always reaches Final,
- Final holds,
- disarming always lands in idle,
- the chosen comparator is always the lowest matching one,
- a pending target never moves before it resolves,
- breakpoint pulses are one-hot and one cycle long.

Other behaviour needs the bench's scenarios. These include the exact cycle in which a force or tagged trigger resolves and the rejection of a same-cycle boundary. They also include the mapping from programmed codes to target states and the masking of trace by secure mode. The bench checks these against a cycle model driven by random and directed stimulus.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int unsigned NUM_SEQ = 3;
  localparam int unsigned CODE_W  = 2;

  typedef enum logic [2:0] {
    ST_ONE   = 3'd0,
    ST_TWO   = 3'd1,
    ST_THREE = 3'd2,
    ST_FINAL = 3'd3,
    ST_IDLE  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    BRK_NONE = 2'd0,
    BRK_DBG  = 2'd1,
    BRK_SWI  = 2'd2,
    BRK_COP  = 2'd3
  } brk_kind_e;
endpackage

// File: rtl/dbg_seq_arb.sv
module dbg_seq_arb
  import dbg_seq_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4,
  localparam int unsigned IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CMP-1:0]         match_i,
  input  logic [NUM_CMP-1:0]         tagged_i,
  input  logic [NUM_CMP*CODE_W-1:0]  cfg_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [CODE_W-1:0]          nxt_o,
  output logic                       tag_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    // scan downward so the lowest index is kept
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    nxt_o = cfg_i[idx_o*CODE_W +: CODE_W];
    tag_o = tagged_i[idx_o];
  end

  // R4
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_i[idx_o] &&
               ((match_i & ((NUM_CMP'(1) << idx_o) - NUM_CMP'(1))) == '0)));
endmodule

// File: rtl/dbg_seq_pend.sv
module dbg_seq_pend
  import dbg_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              load_tag_i,
  input  logic [CODE_W-1:0] load_nxt_i,
  input  logic              boundary_i,
  input  logic              tag_hit_i,
  output logic              fire_o,
  output logic [CODE_W-1:0] fire_nxt_o,
  output logic              busy_o
);
  logic              vld_q;
  logic              tag_q;
  logic [CODE_W-1:0] nxt_q;

  assign fire_o     = vld_q & (tag_q ? tag_hit_i : boundary_i);
  assign fire_nxt_o = nxt_q;
  assign busy_o     = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tag_q <= 1'b0;
      nxt_q <= '0;
    end else if (clr_i || fire_o) begin
      vld_q <= 1'b0;
    end else if (!vld_q && load_i) begin
      vld_q <= 1'b1;
      tag_q <= load_tag_i;
      nxt_q <= load_nxt_i;
    end
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire_o && !clr_i) |=> (busy_o && $stable(fire_nxt_o)));
  // R2
  fire_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !busy_o);
endmodule

// File: rtl/dbg_seq_out.sv
module dbg_seq_out
  import dbg_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      arm_i,
  input  logic      enter_i,
  input  logic      trace_req_i,
  input  brk_kind_e brk_sel_i,
  input  logic      secure_i,
  output logic      trace_o,
  output logic      brk_dbg_o,
  output logic      brk_swi_o,
  output logic      brk_cop_o
);
  logic       trace_q;
  logic [2:0] brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trace_q <= 1'b0;
      brk_q   <= '0;
    end else begin
      if (!arm_i)       trace_q <= 1'b0;
      else if (enter_i) trace_q <= trace_req_i;
      brk_q <= '0;
      if (enter_i) begin
        unique case (brk_sel_i)
          BRK_DBG: brk_q <= 3'b001;
          BRK_SWI: brk_q <= 3'b010;
          BRK_COP: brk_q <= 3'b100;
          default: brk_q <= 3'b000;
        endcase
      end
    end
  end

  // secure mode masks trace capture
  assign trace_o   = trace_q & ~secure_i;
  assign brk_dbg_o = brk_q[0];
  assign brk_swi_o = brk_q[1];
  assign brk_cop_o = brk_q[2];

  // R7
  brk_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({brk_dbg_o, brk_swi_o, brk_cop_o}));
  // R7
  brk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_dbg_o || brk_swi_o || brk_cop_o) |=> !(brk_dbg_o || brk_swi_o || brk_cop_o));
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4,
  localparam int unsigned SLICE_W = NUM_CMP * CODE_W,
  localparam int unsigned CFG_W   = NUM_SEQ * SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic [NUM_CMP-1:0] cmp_match_i,
  input  logic [NUM_CMP-1:0] cmp_tagged_i,
  input  logic [CFG_W-1:0]   nxt_cfg_i,
  input  logic               tag_hi_i,
  input  logic               tag_lo_i,
  input  logic               cop_brk_i,
  input  logic               sw_trig_i,
  input  logic               boundary_i,
  input  logic               tag_hit_i,
  input  logic               secure_i,
  input  logic               trace_req_i,
  input  logic [1:0]         brk_sel_i,
  output logic [2:0]         state_o,
  output logic               trace_en_o,
  output logic               brk_dbg_o,
  output logic               brk_swi_o,
  output logic               brk_cop_o
);
  localparam int unsigned IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

  seq_state_e         state_q, state_d;
  logic               active, direct, enter_final;
  logic [SLICE_W-1:0] slices [NUM_SEQ];
  logic [SLICE_W-1:0] cur_cfg;
  logic               arb_hit, arb_tag;
  logic [IDX_W-1:0]   arb_idx;
  logic [CODE_W-1:0]  arb_nxt;
  logic               pend_fire, pend_busy;
  logic [CODE_W-1:0]  pend_nxt;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_slice
    assign slices[s] = nxt_cfg_i[s*SLICE_W +: SLICE_W];
  end

  assign active = (state_q == ST_ONE) || (state_q == ST_TWO) || (state_q == ST_THREE);
  assign direct = tag_hi_i | tag_lo_i | cop_brk_i | sw_trig_i;

  always_comb begin
    cur_cfg = '0;
    for (int s = 0; s < NUM_SEQ; s++) begin
      if (active && state_q[1:0] == 2'(s)) cur_cfg = slices[s];
    end
  end

  dbg_seq_arb #(.NUM_CMP(NUM_CMP)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (cmp_match_i),
    .tagged_i (cmp_tagged_i),
    .cfg_i    (cur_cfg),
    .hit_o    (arb_hit),
    .idx_o    (arb_idx),
    .nxt_o    (arb_nxt),
    .tag_o    (arb_tag)
  );

  dbg_seq_pend u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~arm_i | ~active | direct),
    .load_i     (arm_i & active & arb_hit & ~direct),
    .load_tag_i (arb_tag),
    .load_nxt_i (arb_nxt),
    .boundary_i (boundary_i),
    .tag_hit_i  (tag_hit_i),
    .fire_o     (pend_fire),
    .fire_nxt_o (pend_nxt),
    .busy_o     (pend_busy)
  );

  always_comb begin
    state_d = state_q;
    if (!arm_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_ONE;
        ST_FINAL: state_d = ST_FINAL;
        default: begin
          if (direct)         state_d = ST_FINAL;
          else if (pend_fire) state_d = seq_state_e'({1'b0, pend_nxt});
        end
      endcase
    end
  end

  assign enter_final = (state_d == ST_FINAL) && (state_q != ST_FINAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  dbg_seq_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .enter_i     (enter_final),
    .trace_req_i (trace_req_i),
    .brk_sel_i   (brk_kind_e'(brk_sel_i)),
    .secure_i    (secure_i),
    .trace_o     (trace_en_o),
    .brk_dbg_o   (brk_dbg_o),
    .brk_swi_o   (brk_swi_o),
    .brk_cop_o   (brk_cop_o)
  );

  assign state_o = state_q;

  // R1
  arm_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && arm_i) |=> (state_o == 3'd0));
  // R6
  shortcut_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && direct && state_o < 3'd3) |=> (state_o == 3'd3));
  // R10
  disarm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (state_o == 3'd4 && !trace_en_o && !pend_busy));
  // R11
  final_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && arm_i) |=> (state_o == 3'd3));
  // R8
  trace_final_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd3) |-> !trace_en_o);
endmodule

// File: tb/dbg_seq_top_tb.sv
module dbg_seq_top_tb;
  localparam int NC = 4;
  localparam int CW = 3 * NC * 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          arm_i;
  logic [NC-1:0] cmp_match_i, cmp_tagged_i;
  logic [CW-1:0] nxt_cfg_i;
  logic          tag_hi_i, tag_lo_i, cop_brk_i, sw_trig_i;
  logic          boundary_i, tag_hit_i, secure_i, trace_req_i;
  logic [1:0]    brk_sel_i;
  logic [2:0]    state_o;
  logic          trace_en_o, brk_dbg_o, brk_swi_o, brk_cop_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  int m_state = 4;
  bit m_pv = 0, m_ptag = 0, m_trace = 0;
  int m_pnxt = 0;
  bit [2:0] m_brk = '0;

  always #4 clk_i = ~clk_i; // 8-unit period, 125 MHz at 1 ns units

  dbg_seq_top #(.NUM_CMP(NC)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_in();
    cmp_match_i = '0; tag_hi_i = 0; tag_lo_i = 0; cop_brk_i = 0;
    sw_trig_i = 0; boundary_i = 0; tag_hit_i = 0; secure_i = 0;
  endtask

  task automatic set_nxt(int s, int c, int code);
    nxt_cfg_i[(s*NC+c)*2 +: 2] = 2'(code);
  endtask

  function automatic bit [2:0] brk_dec(logic [1:0] sel);
    case (sel)
      2'd1: return 3'b001;
      2'd2: return 3'b010;
      2'd3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic model_step();
    bit act, dir, hit, fire, enter;
    int idx, ns;
    act = (m_state <= 2);
    dir = tag_hi_i | tag_lo_i | cop_brk_i | sw_trig_i;
    hit = 0; idx = 0;
    for (int c = 0; c < NC; c++)
      if (!hit && cmp_match_i[c]) begin hit = 1; idx = c; end
    fire = m_pv && (m_ptag ? tag_hit_i : boundary_i);
    if (!arm_i) ns = 4;
    else if (m_state == 4) ns = 0;
    else if (m_state == 3) ns = 3;
    else if (dir) ns = 3;
    else if (fire) ns = m_pnxt;
    else ns = m_state;
    enter = (ns == 3) && (m_state != 3);
    if (!arm_i || !act || dir || fire) m_pv = 0;
    else if (!m_pv && hit) begin
      m_pv = 1;
      m_ptag = cmp_tagged_i[idx];
      m_pnxt = nxt_cfg_i[(m_state*NC+idx)*2 +: 2];
    end
    if (!arm_i) m_trace = 0;
    else if (enter) m_trace = trace_req_i;
    m_brk = enter ? brk_dec(brk_sel_i) : 3'b000;
    m_state = ns;
  endtask

  task automatic compare();
    chk("R2", int'(state_o), m_state);
    chk("R7", int'({brk_cop_o, brk_swi_o, brk_dbg_o}), int'(m_brk));
    chk("R8/R9", int'(trace_en_o), int'(m_trace && !secure_i));
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    clr_in();
    arm_i = 0; cmp_tagged_i = '0; brk_sel_i = 0; trace_req_i = 0;
    for (int s = 0; s < 3; s++) for (int c = 0; c < NC; c++) set_nxt(s, c, s);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", int'(state_o), 4);
    chk("R1", int'({brk_cop_o, brk_swi_o, brk_dbg_o, trace_en_o}), 0);
    arm_i = 1; cyc();
    chk("R1", int'(state_o), 0);

    // force trigger: same-cycle boundary ignored, later boundary applies
    set_nxt(0, 1, 2);
    cmp_match_i = 4'b0010; boundary_i = 1; cyc();
    chk("R2", int'(state_o), 0);
    clr_in(); cyc();
    chk("R2", int'(state_o), 0);
    boundary_i = 1; cyc();
    chk("R2", int'(state_o), 2);

    // tagged trigger waits for tag hit
    clr_in(); set_nxt(2, 0, 1); cmp_tagged_i = 4'b0001;
    cmp_match_i = 4'b0001; cyc();
    clr_in(); boundary_i = 1; cyc();
    chk("R3", int'(state_o), 2);
    clr_in(); tag_hit_i = 1; cyc();
    chk("R3", int'(state_o), 1);
    cmp_tagged_i = '0;

    // priority
    clr_in(); set_nxt(1, 2, 0); set_nxt(1, 3, 2);
    cmp_match_i = 4'b1100; cyc();
    clr_in(); boundary_i = 1; cyc();
    chk("R4", int'(state_o), 0);

    // match while pending is dropped
    clr_in(); set_nxt(0, 0, 1); set_nxt(0, 3, 2);
    cmp_match_i = 4'b0001; cyc();
    clr_in(); cmp_match_i = 4'b1000; cyc();
    clr_in(); boundary_i = 1; cyc();
    chk("R5", int'(state_o), 1);

    // shortcut with pending, breakpoint and trace
    clr_in(); set_nxt(1, 0, 0); cmp_match_i = 4'b0001; cyc();
    clr_in(); brk_sel_i = 2; trace_req_i = 1; sw_trig_i = 1; cyc();
    chk("R6", int'(state_o), 3);
    chk("R7", int'({brk_cop_o, brk_swi_o, brk_dbg_o}), 3'b010);
    clr_in(); cyc();
    chk("R7", int'(brk_swi_o), 0);
    chk("R8", int'(trace_en_o), 1);
    secure_i = 1; #1;
    chk("R9", int'(trace_en_o), 0);
    cyc();
    secure_i = 0; #1;
    chk("R9", int'(trace_en_o), 1);

    // Final holds
    cmp_match_i = '1; cop_brk_i = 1; boundary_i = 1; cyc();
    chk("R11", int'(state_o), 3);
    chk("R11", int'({brk_cop_o, brk_swi_o, brk_dbg_o}), 0);

    // disarm
    clr_in(); arm_i = 0; cyc();
    chk("R10", int'(state_o), 4);
    chk("R10", int'(trace_en_o), 0);
    sw_trig_i = 1; cmp_match_i = '1; cyc();
    chk("R10", int'(state_o), 4);
    chk("R10", int'({brk_cop_o, brk_swi_o, brk_dbg_o}), 0);

    // each other shortcut source
    for (int src = 0; src < 3; src++) begin
      clr_in(); arm_i = 1; brk_sel_i = (src == 0) ? 2'd1 : (src == 1) ? 2'd0 : 2'd3;
      cyc();
      if (src == 0) tag_hi_i = 1; else if (src == 1) tag_lo_i = 1; else cop_brk_i = 1;
      cyc();
      chk("R6", int'(state_o), 3);
      chk("R7", int'({brk_cop_o, brk_swi_o, brk_dbg_o}), int'(brk_dec(brk_sel_i)));
      clr_in(); arm_i = 0; cyc();
    end

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) begin
        for (int s = 0; s < 3; s++)
          for (int c = 0; c < NC; c++) set_nxt(s, c, $urandom_range(0, 3));
        cmp_tagged_i = NC'($urandom);
      end
      arm_i = ($urandom_range(0, 99) >= 2);
      for (int c = 0; c < NC; c++) cmp_match_i[c] = ($urandom_range(0, 7) == 0);
      tag_hi_i   = ($urandom_range(0, 299) == 0);
      tag_lo_i   = ($urandom_range(0, 299) == 0);
      cop_brk_i  = ($urandom_range(0, 299) == 0);
      sw_trig_i  = ($urandom_range(0, 299) == 0);
      boundary_i = ($urandom_range(0, 2) == 0);
      tag_hit_i  = ($urandom_range(0, 4) == 0);
      secure_i   = ($urandom_range(0, 3) == 0);
      trace_req_i = ($urandom_range(0, 3) != 0);
      brk_sel_i  = 2'($urandom_range(0, 3));
      cyc();
    end

    finish_run();
  end
endmodule